// File: doc/BRIEF.md
# Host-to-DSP Memory Transfer Bridge

This block sits on the host side of a host/DSP pair and moves 16-bit words between the host and the DSP's memory. Host writes enter a 16-word write queue. The block drains that queue into DSP memory on its own. Host reads come from a 16-word read queue, which the block fills from DSP memory when a read burst is launched. Both host-facing data paths are valid/ready streams. On the push side, `s_ready` is low while the write queue holds 16 words, and a word is taken on every cycle where `s_valid` and `s_ready` are both high. On the pop side, `m_valid` is high while the read queue holds a word, and a word leaves on every cycle where `m_valid` and `m_ready` are both high. The host can keep `m_ready` low for as long as it likes: fetching then stalls, and no word is lost.

Configuration arrives on plain pins:
- a DSP reset request,
- address auto-increment,
- a 2-bit read length code,
- a read start level,
- four interrupt enables,
- a 4-bit memory-space code.

A 16-bit transfer cursor is loaded through `addr_load`/`addr_value`. The DSP-side memory port is a single request/acknowledge interface with one request outstanding at a time. Reads and writes share it, and writes take priority. Status pins report whether a read or write is underway and the levels of both queues. The `dsp_reset` pin also serves as the reset-busy status.

Top module: `dxfer_top`

## Requirements
- R1: A word offered on `s_data` with `s_valid` high is stored in the write queue when `s_ready` is high. `s_ready` and `st_wr_full` read 0 and 1 respectively once 16 words are held.
- R2: `m_valid` is high exactly when the read queue holds a word. Words leave on `m_data` in the order they were fetched, one per cycle with `m_valid` and `m_ready` high.
- R3: A rising edge of `cfg_rd_start` launches a read burst whose length follows `cfg_rd_len`: 0 gives 1 word, 1 gives 8 words, 2 gives 16 words. `st_rd_busy` is high from the next cycle until the last word is queued.
- R4: With `cfg_rd_len` = 3 the burst runs freely while `cfg_rd_start` stays high. No request is issued while the read queue is full. Fetching resumes when space frees. After `cfg_rd_start` falls, no new word is requested, and `st_rd_busy` clears once any outstanding word has arrived.
- R5: A fixed-length burst that meets a full read queue waits without dropping or skipping a word, and completes after the host pops.
- R6: With `cfg_auto_inc` = 1 the cursor advances by one after every completed transfer, read or write. With `cfg_auto_inc` = 0 it stays put. `addr_load` overwrites the cursor.
- R7: `cfg_space` routes each request through `mem_sel`. Code 0 gives bit 0 (data memory), code 1 gives bit 1 (register space) and code 5 gives bit 2 (program memory). Any other code issues no request.
- R8: Queue status pins are exact: `st_rd_full`, `st_rd_nempty`, `st_wr_full` and `st_wr_empty` (the last is 1 after reset).
- R9: `dsp_reset` is high while `cfg_dsp_reset` is high and for RST_HOLD (default 8) cycles after it falls. No memory request starts while `dsp_reset` is high.
- R10: `irq` is the OR of enabled conditions: `cfg_irq_en[0]` enables read-full, [1] read-not-empty, [2] write-full and [3] write-empty.
- R11: `mem_req` stays high, with stable `mem_addr`, `mem_we`, `mem_sel` and `mem_wdata`, until the cycle of `mem_ack`. When a write and a read are both pending, the write is issued first.
- R12: `st_wr_busy` is high while the write queue holds words or a write request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Host write word valid |
| s_ready | output | 1 | Write queue can take a word |
| s_data | input | 16 | Host write word |
| m_valid | output | 1 | Read queue has a word |
| m_ready | input | 1 | Host takes the read word |
| m_data | output | 16 | Head of the read queue |
| cfg_dsp_reset | input | 1 | DSP reset request |
| cfg_auto_inc | input | 1 | Cursor auto-increment enable |
| cfg_rd_len | input | 2 | Read length code |
| cfg_rd_start | input | 1 | Read start level (rising edge launches) |
| cfg_irq_en | input | 4 | Interrupt enables |
| cfg_space | input | 4 | Memory space code |
| addr_load | input | 1 | Load the transfer cursor |
| addr_value | input | 16 | Cursor load value |
| st_rd_busy | output | 1 | Read burst underway |
| st_wr_busy | output | 1 | Write transfer underway |
| st_rd_full | output | 1 | Read queue full |
| st_rd_nempty | output | 1 | Read queue not empty |
| st_wr_full | output | 1 | Write queue full |
| st_wr_empty | output | 1 | Write queue empty |
| irq | output | 1 | Interrupt request |
| dsp_reset | output | 1 | DSP reset, held for the minimum time; also reset-busy |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_sel | output | 3 | One-hot memory space select |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 16 | Read data |

## Verification
Two coincidences matter most here.

The first is a fetched word landing in the read queue in the same cycle as a host pop. A free-running burst is first allowed to fill the queue. `m_ready` is then held high, so pushes and pops overlap over many cycles. A scoreboard of address-derived expected words judges the result: every word must arrive once, in order, with none lost or repeated.

The second is a write drain and a read burst becoming eligible for the port in the same cycle. This is provoked by parking both behind an unroutable space code and then switching to a valid one. The test requires the first request after the switch to be a write.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;

  localparam int WORD_W = 16;

  localparam logic [1:0] LEN_ONE     = 2'd0;
  localparam logic [1:0] LEN_EIGHT   = 2'd1;
  localparam logic [1:0] LEN_SIXTEEN = 2'd2;
  localparam logic [1:0] LEN_FREE    = 2'd3;

  localparam logic [3:0] SPACE_DATA = 4'd0;
  localparam logic [3:0] SPACE_REGS = 4'd1;
  localparam logic [3:0] SPACE_PROG = 4'd5;

  // One-hot route for a space code; zero means the code is not routable.
  function automatic logic [2:0] space_route(input logic [3:0] code);
    case (code)
      SPACE_DATA: return 3'b001;
      SPACE_REGS: return 3'b010;
      SPACE_PROG: return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction

  // Word count of a fixed-length burst code.
  function automatic logic [4:0] burst_words(input logic [1:0] len);
    case (len)
      LEN_ONE:     return 5'd1;
      LEN_EIGHT:   return 5'd8;
      LEN_SIXTEEN: return 5'd16;
      default:     return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/dxfer_fifo.sv
module dxfer_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign pop_data = store[rp];
  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/dxfer_rst_hold.sv
module dxfer_rst_hold #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= '0;
    else if (req)          remain <= CW'(HOLD);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = req || (remain != '0);

  // R9
  hold_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> busy);

endmodule

// File: rtl/dxfer_rd_ctl.sv
module dxfer_rd_ctl
  import dxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] len,
  input  logic       fifo_full,
  input  logic       rd_done,
  input  logic       rd_pending,
  output logic       want,
  output logic       busy
);
  logic       start_q;
  logic       active;
  logic       free;
  logic [4:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      active  <= 1'b0;
      free    <= 1'b0;
      left    <= '0;
    end else begin
      start_q <= start;
      if (!active) begin
        if (start && !start_q) begin
          active <= 1'b1;
          free   <= (len == LEN_FREE);
          left   <= burst_words(len);
        end
      end else if (free) begin
        if (!start && !rd_pending) active <= 1'b0;
      end else if (rd_done) begin
        left <= left - 1'b1;
        if (left == 5'd1) active <= 1'b0;
      end
    end
  end

  assign want = active && !fifo_full && (free ? start : 1'b1);
  assign busy = active;

  // R3
  launch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R5
  word_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> busy);
  // R4
  free_run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && free && start) |=> busy);

endmodule

// File: rtl/dxfer_port_arb.sv
module dxfer_port_arb
  import dxfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_off,
  input  logic [3:0]    space,
  input  logic          auto_inc,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_value,
  input  logic          wr_want,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_want,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [2:0]    mem_sel,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          wr_done,
  output logic          rd_done,
  output logic          wr_pending,
  output logic          rd_pending
);
  logic [AW-1:0] cursor;
  logic [2:0]    route;
  logic          can_issue;

  assign route     = space_route(space);
  assign can_issue = !mem_req && (route != 3'b000) && !hold_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cursor <= '0;
    end else if (addr_load) begin
      cursor <= addr_value;
    end else if (mem_req && mem_ack && auto_inc) begin
      cursor <= cursor + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_sel   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (can_issue && (wr_want || rd_want)) begin
      mem_req   <= 1'b1;
      mem_we    <= wr_want;
      mem_sel   <= route;
      mem_addr  <= cursor;
      mem_wdata <= wr_word;
    end
  end

  assign wr_done    = mem_req && mem_we && mem_ack;
  assign rd_done    = mem_req && !mem_we && mem_ack;
  assign wr_pending = mem_req && mem_we;
  assign rd_pending = mem_req && !mem_we;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_sel)));
  // R11
  wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (can_issue && wr_want && rd_want) |=> (mem_req && mem_we));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && auto_inc && !addr_load) |=> (cursor == $past(cursor) + 1'b1));
  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_sel) == 1));

endmodule

// File: rtl/dxfer_top.sv
module dxfer_top
  import dxfer_pkg::*;
#(
  parameter int DATA_W   = WORD_W,
  parameter int ADDR_W   = 16,
  parameter int RD_DEPTH = 16,
  parameter int WR_DEPTH = 16,
  parameter int RST_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              cfg_dsp_reset,
  input  logic              cfg_auto_inc,
  input  logic [1:0]        cfg_rd_len,
  input  logic              cfg_rd_start,
  input  logic [3:0]        cfg_irq_en,
  input  logic [3:0]        cfg_space,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_value,
  output logic              st_rd_busy,
  output logic              st_wr_busy,
  output logic              st_rd_full,
  output logic              st_rd_nempty,
  output logic              st_wr_full,
  output logic              st_wr_empty,
  output logic              irq,
  output logic              dsp_reset,
  output logic              mem_req,
  output logic              mem_we,
  output logic [2:0]        mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              wr_full, wr_empty, rd_full, rd_empty;
  logic [DATA_W-1:0] wr_head;
  logic              wr_done, rd_done, wr_pending, rd_pending;
  logic              rd_want;

  dxfer_rst_hold #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst_n(rst_n), .req(cfg_dsp_reset), .busy(dsp_reset)
  );

  dxfer_fifo #(.W(DATA_W), .DEPTH(WR_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .push(s_valid && s_ready), .push_data(s_data),
    .pop(wr_done), .pop_data(wr_head),
    .full(wr_full), .empty(wr_empty)
  );

  dxfer_fifo #(.W(DATA_W), .DEPTH(RD_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n),
    .push(rd_done), .push_data(mem_rdata),
    .pop(m_valid && m_ready), .pop_data(m_data),
    .full(rd_full), .empty(rd_empty)
  );

  dxfer_rd_ctl u_rd (
    .clk(clk), .rst_n(rst_n),
    .start(cfg_rd_start), .len(cfg_rd_len),
    .fifo_full(rd_full), .rd_done(rd_done), .rd_pending(rd_pending),
    .want(rd_want), .busy(st_rd_busy)
  );

  dxfer_port_arb #(.AW(ADDR_W), .W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .hold_off(dsp_reset), .space(cfg_space), .auto_inc(cfg_auto_inc),
    .addr_load(addr_load), .addr_value(addr_value),
    .wr_want(!wr_empty), .wr_word(wr_head), .rd_want(rd_want),
    .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_done(wr_done), .rd_done(rd_done),
    .wr_pending(wr_pending), .rd_pending(rd_pending)
  );

  assign s_ready      = !wr_full;
  assign m_valid      = !rd_empty;
  assign st_rd_full   = rd_full;
  assign st_rd_nempty = !rd_empty;
  assign st_wr_full   = wr_full;
  assign st_wr_empty  = wr_empty;
  assign st_wr_busy   = wr_pending || !wr_empty;
  assign irq          = |(cfg_irq_en & {wr_empty, wr_full, !rd_empty, rd_full});

  // R9
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_reset && !mem_req) |=> !mem_req);
  // R12
  wr_busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> st_wr_busy);
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irq_en == 4'b0000) |-> !irq);

endmodule

// File: tb/dxfer_top_test.sv
module dxfer_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_data;
  logic        cfg_dsp_reset = 1'b0, cfg_auto_inc = 1'b1, cfg_rd_start = 1'b0;
  logic [1:0]  cfg_rd_len = 2'd0;
  logic [3:0]  cfg_irq_en = 4'd0, cfg_space = 4'd0;
  logic        addr_load = 1'b0;
  logic [15:0] addr_value = '0;
  logic        st_rd_busy, st_wr_busy, st_rd_full, st_rd_nempty, st_wr_full, st_wr_empty;
  logic        irq, dsp_reset, mem_req, mem_we;
  logic [2:0]  mem_sel;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [15:0] mem_rdata;

  always #4 clk = ~clk;

  dxfer_top uut (.*);

  int checks = 0, fails = 0, pops = 0, req_rises = 0, model_lat = 0, wait_n = 0;
  logic [15:0] mem_d [3][256];
  logic        rise_log [512];
  logic        req_q = 1'b0;
  logic [15:0] exp_q [$];

  function automatic logic [15:0] model_word(int s, int a);
    return 16'(((s + 1) << 12) ^ (a * 16'h0101) ^ 16'h0033);
  endfunction

  function automatic int sidx(logic [2:0] sel);
    return sel[2] ? 2 : (sel[1] ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Memory model: acknowledges after model_lat idle cycles, one request at a time.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wait_n  <= 0;
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 256; a++) mem_d[s][a] <= model_word(s, a);
    end else if (mem_req && !mem_ack) begin
      if (wait_n >= model_lat) begin
        mem_ack <= 1'b1;
        wait_n  <= 0;
        if (mem_we) mem_d[sidx(mem_sel)][mem_addr[7:0]] <= mem_wdata;
        else        mem_rdata <= mem_d[sidx(mem_sel)][mem_addr[7:0]];
      end else begin
        wait_n <= wait_n + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    req_q <= mem_req;
    if (rst_n && mem_req && !req_q) begin
      rise_log[req_rises % 512] <= mem_we;
      req_rises <= req_rises + 1;
    end
  end

  // Scoreboard monitor (R2).
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      pops++;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", int'(m_data), 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        chk(m_data == e, "R2 read order", int'(m_data), int'(e));
      end
    end
  end

  task automatic load_addr(input logic [15:0] a);
    addr_load = 1'b1; addr_value = a; step(); addr_load = 1'b0;
  endtask

  task automatic launch(input logic [1:0] len);
    cfg_rd_len = len; cfg_rd_start = 1'b0; step();
    cfg_rd_start = 1'b1; step();
  endtask

  task automatic wait_rd_idle(input int lim);
    for (int i = 0; i < lim && (st_rd_busy || (m_ready && m_valid)); i++) step();
  endtask

  task automatic run_burst(input logic [1:0] len, input int n, input logic [15:0] a,
                           input int s, input bit inc, input string tag);
    int p0;
    cfg_auto_inc = inc;
    load_addr(a);
    for (int i = 0; i < n; i++) exp_q.push_back(model_word(s, inc ? a + i : a));
    p0 = pops;
    launch(len);
    cfg_rd_start = 1'b0;
    wait_rd_idle(400);
    @(negedge clk);
    chk(pops - p0 == n, tag, pops - p0, n);
    chk(!st_rd_busy && exp_q.size() == 0, tag, int'(st_rd_busy), 0);
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int r0, p0, base;
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!st_rd_busy && !st_wr_busy, "R12 reset busy flags", int'({st_rd_busy, st_wr_busy}), 0);
    chk(st_wr_empty && !st_wr_full && !st_rd_full && !st_rd_nempty, "R8 reset flags",
        int'({st_wr_empty, st_wr_full, st_rd_full, st_rd_nempty}), 8);
    chk(!irq && !mem_req && !dsp_reset && s_ready && !m_valid, "R9 reset outputs",
        int'({irq, mem_req, dsp_reset}), 0);

    // R9: hold time and quiet port, with a write parked behind the reset.
    step();
    load_addr(16'h0040);
    cfg_dsp_reset = 1'b1; s_valid = 1'b1; s_data = 16'hABCD;
    step();
    cfg_dsp_reset = 1'b0; s_valid = 1'b0;
    r0 = req_rises;
    begin
      int held = 0;
      @(negedge clk);
      while (dsp_reset && held < 50) begin held++; @(negedge clk); end
      chk(held == 8, "R9 reset hold cycles", held, 8);
    end
    chk(req_rises == r0, "R9 no request during reset", req_rises - r0, 0);
    @(negedge clk);
    chk(st_wr_busy, "R12 write underway", int'(st_wr_busy), 1);
    step(6);
    chk(mem_d[0][8'h40] == 16'hABCD, "R1 write stored", int'(mem_d[0][8'h40]), 16'hABCD);
    chk(!st_wr_busy && st_wr_empty, "R12 write done", int'(st_wr_busy), 0);
    s_valid = 1'b1; s_data = 16'h1234; step(); s_valid = 1'b0;
    step(6);
    chk(mem_d[0][8'h41] == 16'h1234, "R6 write cursor advanced", int'(mem_d[0][8'h41]), 16'h1234);

    // R3: the three fixed lengths with a slow memory.
    m_ready = 1'b1; model_lat = 2;
    run_burst(2'd0, 1, 16'h0010, 0, 1'b1, "R3 len 1");
    run_burst(2'd1, 8, 16'h0020, 0, 1'b1, "R3 len 8");
    run_burst(2'd2, 16, 16'h0030, 0, 1'b1, "R3 len 16");
    // R6: fixed address.
    run_burst(2'd1, 8, 16'h0050, 0, 1'b0, "R6 no increment");

    // R5/R7: fill from program memory without popping, then stall a second burst.
    model_lat = 0; m_ready = 1'b0; cfg_space = 4'd5; cfg_auto_inc = 1'b1;
    load_addr(16'h0060);
    for (int i = 0; i < 16; i++) exp_q.push_back(model_word(2, 16'h0060 + i));
    launch(2'd2); cfg_rd_start = 1'b0;
    for (int i = 0; i < 200 && st_rd_busy; i++) step();
    @(negedge clk);
    chk(st_rd_full && st_rd_nempty && !st_rd_busy, "R5 full after 16",
        int'({st_rd_full, st_rd_nempty, st_rd_busy}), 6);
    cfg_irq_en = 4'b0001; #1;
    chk(irq, "R10 read-full irq", int'(irq), 1);
    cfg_irq_en = 4'b0000; #1;
    chk(!irq, "R10 masked", int'(irq), 0);
    step();
    load_addr(16'h0070);
    exp_q.push_back(model_word(2, 16'h0070));
    r0 = req_rises;
    launch(2'd0); cfg_rd_start = 1'b0;
    step(10);
    chk(st_rd_busy && req_rises == r0, "R5 stall on full", req_rises - r0, 0);
    m_ready = 1'b1;
    wait_rd_idle(400);
    @(negedge clk);
    chk(exp_q.size() == 0 && !m_valid, "R5 stalled word delivered", exp_q.size(), 0);
    chk(!st_rd_full, "R8 full cleared", int'(st_rd_full), 0);

    // R4: free run in register space, pause on full, overlap push and pop.
    step(); m_ready = 1'b0; cfg_space = 4'd1;
    load_addr(16'h0080);
    for (int i = 0; i < 48; i++) exp_q.push_back(model_word(1, 16'h0080 + i));
    p0 = pops;
    launch(2'd3);
    for (int i = 0; i < 200 && !st_rd_full; i++) step();
    step(2);
    r0 = req_rises;
    step(10);
    chk(st_rd_busy && req_rises == r0, "R4 pause while full", req_rises - r0, 0);
    m_ready = 1'b1;
    step(20);
    cfg_rd_start = 1'b0;
    wait_rd_idle(400);
    @(negedge clk);
    chk(!st_rd_busy && !m_valid, "R4 stop after start falls", int'(st_rd_busy), 0);
    chk(pops - p0 > 16, "R4 resumed after space freed", pops - p0, 17);
    exp_q.delete();
    step();

    // R11/R7/R1: park writes and a read behind an unroutable code.
    cfg_space = 4'd3; cfg_auto_inc = 1'b1;
    load_addr(16'h0090);
    r0 = req_rises;
    for (int i = 0; i < 16; i++) begin
      s_valid = 1'b1; s_data = 16'hC000 + 16'(i); step();
    end
    s_valid = 1'b0;
    launch(2'd0); cfg_rd_start = 1'b0;
    step(8);
    @(negedge clk);
    chk(req_rises == r0, "R7 unroutable space issues nothing", req_rises - r0, 0);
    chk(!s_ready && st_wr_full, "R1 write queue full", int'({s_ready, st_wr_full}), 1);
    chk(st_wr_busy && st_rd_busy, "R12 both pending", int'({st_wr_busy, st_rd_busy}), 3);
    cfg_irq_en = 4'b0100; #1;
    chk(irq, "R10 write-full irq", int'(irq), 1);
    exp_q.push_back(model_word(0, 16'h00A0));
    base = req_rises;
    step();
    cfg_space = 4'd0;
    for (int i = 0; i < 400 && (st_rd_busy || st_wr_busy || m_valid); i++) step();
    @(negedge clk);
    chk(rise_log[base % 512] == 1'b1, "R11 write first", int'(rise_log[base % 512]), 1);
    chk(mem_d[0][8'h90] == 16'hC000, "R1 first write", int'(mem_d[0][8'h90]), 16'hC000);
    chk(mem_d[0][8'h9F] == 16'hC00F, "R1 last write", int'(mem_d[0][8'h9F]), 16'hC00F);
    chk(exp_q.size() == 0, "R11 read after writes", exp_q.size(), 0);
    cfg_irq_en = 4'b1000; #1;
    chk(irq && st_wr_empty, "R10 write-empty irq", int'(irq), 1);
    cfg_irq_en = 4'b0010; #1;
    chk(!irq, "R10 read-not-empty idle", int'(irq), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule